// File: doc/BRIEF.md
# Dataflow Periodic Schedule Builder

This block works out a periodic sequential firing order for a fixed-rate dataflow graph of three actors (codes A=0, B=1, C=2) joined by three edges. Each edge has its own producer and consumer actor, production and consumption rates and a starting token count. Each actor has a target firing count. All of these arrive on configuration ports and are captured when `start` is pulsed. The engine then tries one actor per clock in the fixed rotation A, B, C. An actor fires when its count is below its target and every edge it consumes from holds at least that edge's consumption rate. The engine keeps the token marking of every edge up to date and streams out the code of each actor that fires.

A run ends in one of three terminal states. Completion means every count has reached its target, and the engine then compares the marking with the starting marking. Deadlock means a whole rotation of attempts fired nothing. Overflow means a firing would push an 8-bit token counter past its limit. The terminal state holds until the next `start`. It is meant as a hardware helper that checks and records a candidate firing vector before software commits the schedule.

States: IDLE (after reset), RUN (one attempt per cycle), DONE, DEAD, OVF. Transitions: IDLE/DONE/DEAD/OVF to RUN on `start`. RUN to DONE when all counts meet their targets. RUN to OVF when an eligible firing would overflow a counter. RUN to DEAD when the attempt on C closes a rotation in which nothing fired. RUN to RUN in every other case.

Top module: `sdf_sched_engine`

## Requirements
- R1: After reset the engine is in IDLE: `busy`, `done`, `deadlock`, `overflow`, `tok_err` and `fire_valid` are all low.
- R2: A `start` pulse outside RUN captures the configuration, sets each edge's tokens to its start count and each actor's count to zero, and enters RUN on the next edge. A `start` during RUN is ignored and does not change the emitted sequence.
- R3: In RUN the engine makes one attempt per cycle in the order A(0), B(1), C(2), then A again. An actor fires only if its count is below its target and every edge whose consumer field equals its code holds at least that edge's consumption rate.
- R4: On a firing, each edge whose producer field equals the actor's code gains the production rate and each edge whose consumer field equals it loses the consumption rate. Field code 3 names no actor.
- R5: Each firing raises `fire_valid` for exactly one cycle, starting the cycle after the attempt, with `fire_actor` carrying the 2-bit actor code.
- R6: At the start of each RUN cycle, if every count equals its target the engine enters DONE, and `tok_err` is high when any edge's tokens differ from its start count.
- R7: If the attempt on C closes a rotation in which no actor fired, the engine enters DEAD.
- R8: If an eligible firing would leave any 8-bit token counter above 255, the engine enters OVF without firing or emitting anything.
- R9: DONE, DEAD and OVF hold with `busy` low until the next `start`, and that `start` begins a fresh run.
- R10: With edges A->B (2 produced, 4 consumed), A->C (1, 2) and B->C (1, 1), targets A=2, B=1, C=1 and no starting tokens, the emitted order is A, A, B, C and the run ends in DONE with `tok_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored in RUN) |
| edge_src | input | 6 | Producer actor code per edge, 2 bits each, edge 0 lowest |
| edge_dst | input | 6 | Consumer actor code per edge, 2 bits each |
| edge_prod | input | 12 | Production rate per edge, 4 bits each |
| edge_cons | input | 12 | Consumption rate per edge, 4 bits each |
| edge_init | input | 24 | Starting token count per edge, 8 bits each |
| actor_tgt | input | 24 | Target firing count per actor, 8 bits each, A lowest |
| busy | output | 1 | High in RUN |
| done | output | 1 | High in DONE |
| deadlock | output | 1 | High in DEAD |
| overflow | output | 1 | High in OVF |
| tok_err | output | 1 | Marking at completion differs from the start marking |
| fire_valid | output | 1 | One-cycle strobe per firing |
| fire_actor | output | 2 | Code of the actor that fired |

## Verification
The bench builds the block with its default parameters: three edges, 4-bit rates, 8-bit token counters and 8-bit firing counts. With 8-bit counters, a starting count of 254 on an edge where A produces 2 reaches the overflow stop in the first attempt. The small rates let the bench exercise the balanced default graph, the reversed-edge deadlock, a graph that starts with tokens and so fires in a different order, an unbalanced target that leaves a wrong marking, and an all-zero target that completes at once. A behavioural model compares every output on every cycle.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int NA = 3;
    localparam int AW = 2;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RUN  = 3'd1,
        S_DONE = 3'd2,
        S_DEAD = 3'd3,
        S_OVF  = 3'd4
    } sched_st_t;
endpackage

// File: rtl/sdf_fire_check.sv
module sdf_fire_check #(
    parameter int NE = 3,
    parameter int RW = 4,
    parameter int TW = 8,
    parameter int AW = 2
) (
    input  logic [AW-1:0]    actor,
    input  logic [NE*AW-1:0] src,
    input  logic [NE*AW-1:0] dst,
    input  logic [NE*RW-1:0] prod,
    input  logic [NE*RW-1:0] cons,
    input  logic [NE*TW-1:0] tok,
    output logic [NE*TW-1:0] tok_nxt,
    output logic             ready,
    output logic             ovf
);
    logic [NE-1:0] short_e;
    logic [NE-1:0] ovf_e;

    for (genvar e = 0; e < NE; e++) begin : g_edge
        logic          is_src, is_dst;
        logic [RW-1:0] p_eff, c_eff;
        logic [TW:0]   sum;
        assign is_src  = (src[e*AW +: AW] == actor);
        assign is_dst  = (dst[e*AW +: AW] == actor);
        assign p_eff   = is_src ? prod[e*RW +: RW] : '0;
        assign c_eff   = is_dst ? cons[e*RW +: RW] : '0;
        assign short_e[e] = is_dst && (tok[e*TW +: TW] < TW'(cons[e*RW +: RW]));
        assign sum     = {1'b0, tok[e*TW +: TW]} + (TW+1)'(p_eff) - (TW+1)'(c_eff);
        assign ovf_e[e] = !short_e[e] && sum[TW];
        assign tok_nxt[e*TW +: TW] = sum[TW-1:0];
    end

    assign ready = ~|short_e;
    assign ovf   = |ovf_e;
endmodule

// File: rtl/sdf_token_bank.sv
module sdf_token_bank #(
    parameter int NE = 3,
    parameter int TW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             fire,
    input  logic [NE*TW-1:0] init,
    input  logic [NE*TW-1:0] tok_nxt,
    output logic [NE*TW-1:0] tok
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tok <= '0;
        else if (load) tok <= init;
        else if (fire) tok <= tok_nxt;
    end

    // R4: the marking only moves on a load or a firing
    a_r4_marking_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !fire) |=> $stable(tok));
endmodule

// File: rtl/sdf_sched_engine.sv
module sdf_sched_engine
    import sdf_pkg::*;
#(
    parameter int NE = 3,
    parameter int RW = 4,
    parameter int TW = 8,
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NE*AW-1:0] edge_src,
    input  logic [NE*AW-1:0] edge_dst,
    input  logic [NE*RW-1:0] edge_prod,
    input  logic [NE*RW-1:0] edge_cons,
    input  logic [NE*TW-1:0] edge_init,
    input  logic [NA*CW-1:0] actor_tgt,
    output logic             busy,
    output logic             done,
    output logic             deadlock,
    output logic             overflow,
    output logic             tok_err,
    output logic             fire_valid,
    output logic [AW-1:0]    fire_actor
);
    localparam logic [AW-1:0] LAST = AW'(NA - 1);

    sched_st_t st_q, st_n;

    logic [NE*AW-1:0] src_q, dst_q;
    logic [NE*RW-1:0] prod_q, cons_q;
    logic [NE*TW-1:0] init_q;
    logic [NA*CW-1:0] tgt_q;
    logic [CW-1:0]    cnt_q [NA];
    logic [AW-1:0]    cur_q;
    logic             pass_q;

    logic [NE*TW-1:0] tok, tok_nxt;
    logic             ready, ovf_hit;
    logic [NA-1:0]    met;
    logic             all_met, below, elig, do_fire, go_ovf, load;

    for (genvar a = 0; a < NA; a++) begin : g_met
        assign met[a] = (cnt_q[a] == tgt_q[a*CW +: CW]);
    end

    assign all_met = &met;
    assign below   = (cnt_q[cur_q] < tgt_q[cur_q*CW +: CW]);
    assign elig    = (st_q == S_RUN) && !all_met && below && ready;
    assign do_fire = elig && !ovf_hit;
    assign go_ovf  = elig && ovf_hit;
    assign load    = (st_q != S_RUN) && start;

    sdf_fire_check #(.NE(NE), .RW(RW), .TW(TW), .AW(AW)) i_check (
        .actor  (cur_q),
        .src    (src_q),
        .dst    (dst_q),
        .prod   (prod_q),
        .cons   (cons_q),
        .tok    (tok),
        .tok_nxt(tok_nxt),
        .ready  (ready),
        .ovf    (ovf_hit)
    );

    sdf_token_bank #(.NE(NE), .TW(TW)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .fire   (do_fire),
        .init   (edge_init),
        .tok_nxt(tok_nxt),
        .tok    (tok)
    );

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_IDLE, S_DONE, S_DEAD, S_OVF: begin
                if (start) st_n = S_RUN;
            end
            S_RUN: begin
                if (all_met)                                    st_n = S_DONE;
                else if (go_ovf)                                st_n = S_OVF;
                else if (cur_q == LAST && !(pass_q || do_fire)) st_n = S_DEAD;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; prod_q <= '0; cons_q <= '0;
            init_q <= '0; tgt_q <= '0;
            cur_q <= '0; pass_q <= 1'b0;
            fire_valid <= 1'b0; fire_actor <= '0; tok_err <= 1'b0;
            for (int a = 0; a < NA; a++) cnt_q[a] <= '0;
        end else begin
            fire_valid <= do_fire;
            if (do_fire) fire_actor <= cur_q;
            if (load) begin
                src_q <= edge_src; dst_q <= edge_dst;
                prod_q <= edge_prod; cons_q <= edge_cons;
                init_q <= edge_init; tgt_q <= actor_tgt;
                cur_q <= '0; pass_q <= 1'b0; tok_err <= 1'b0;
                for (int a = 0; a < NA; a++) cnt_q[a] <= '0;
            end else if (st_q == S_RUN) begin
                if (all_met) begin
                    tok_err <= (tok != init_q);
                end else if (!go_ovf) begin
                    if (do_fire) cnt_q[cur_q] <= cnt_q[cur_q] + 1'b1;
                    if (cur_q == LAST) begin
                        cur_q  <= '0;
                        pass_q <= 1'b0;
                    end else begin
                        cur_q  <= cur_q + 1'b1;
                        pass_q <= pass_q | do_fire;
                    end
                end
            end
        end
    end

    assign busy     = (st_q == S_RUN);
    assign done     = (st_q == S_DONE);
    assign deadlock = (st_q == S_DEAD);
    assign overflow = (st_q == S_OVF);

    // R3: a firing never draws an edge below zero
    for (genvar e = 0; e < NE; e++) begin : g_chk
        a_r3_enough_tokens: assert property (@(posedge clk) disable iff (!rst_n)
            (do_fire && dst_q[e*AW +: AW] == cur_q) |-> (tok[e*TW +: TW] >= TW'(cons_q[e*RW +: RW])));
    end
    for (genvar a = 0; a < NA; a++) begin : g_cnt
        // R3: no actor exceeds its target
        a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == S_RUN) |-> (cnt_q[a] <= tgt_q[a*CW +: CW]));
    end
    // R5: a strobe only follows a cycle spent in RUN
    a_r5_strobe_origin: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid |-> $past(busy));
    // R8: nothing is emitted while stopped on overflow
    a_r8_ovf_silent: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !fire_valid);
    // R9: completion holds until a new start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: tb/test_sdf_sched_engine.sv
module test_sdf_sched_engine;
    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [5:0]  e_src, e_dst;
    logic [11:0] e_prod, e_cons;
    logic [23:0] e_init, a_tgt;
    logic busy, done, deadlock, overflow, tok_err, fire_valid;
    logic [1:0] fire_actor;

    always #10 clk = ~clk;

    sdf_sched_engine i_sdf_sched_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .edge_src(e_src), .edge_dst(e_dst), .edge_prod(e_prod), .edge_cons(e_cons),
        .edge_init(e_init), .actor_tgt(a_tgt),
        .busy(busy), .done(done), .deadlock(deadlock), .overflow(overflow),
        .tok_err(tok_err), .fire_valid(fire_valid), .fire_actor(fire_actor)
    );

    int total = 0, bad = 0;
    int seq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 run, 2 done, 3 dead, 4 ovf
    int ms, mc, ma, mv, merr;
    bit mp;
    int tok[3], cnt[3], tgt[3], src[3], dst[3], prd[3], cns[3], ini[3], nt[3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mc = 0; ma = 0; mv = 0; merr = 0; mp = 0;
        end else begin
            mv = 0;
            if (ms != 1) begin
                if (start) begin
                    ms = 1; mc = 0; mp = 0; merr = 0;
                    for (int e = 0; e < 3; e++) begin
                        src[e] = e_src[e*2 +: 2]; dst[e] = e_dst[e*2 +: 2];
                        prd[e] = e_prod[e*4 +: 4]; cns[e] = e_cons[e*4 +: 4];
                        ini[e] = e_init[e*8 +: 8]; tok[e] = ini[e];
                    end
                    for (int a = 0; a < 3; a++) begin
                        tgt[a] = a_tgt[a*8 +: 8]; cnt[a] = 0;
                    end
                end
            end else begin
                bit all_ok, ok, ov, fired;
                all_ok = 1;
                for (int a = 0; a < 3; a++) if (cnt[a] != tgt[a]) all_ok = 0;
                if (all_ok) begin
                    ms = 2;
                    for (int e = 0; e < 3; e++) if (tok[e] != ini[e]) merr = 1;
                end else begin
                    ok = (cnt[mc] < tgt[mc]);
                    for (int e = 0; e < 3; e++) if (dst[e] == mc && tok[e] < cns[e]) ok = 0;
                    ov = 0; fired = 0;
                    if (ok) begin
                        for (int e = 0; e < 3; e++) begin
                            nt[e] = tok[e];
                            if (src[e] == mc) nt[e] += prd[e];
                            if (dst[e] == mc) nt[e] -= cns[e];
                            if (nt[e] > 255) ov = 1;
                        end
                        if (ov) ms = 4;
                        else begin
                            for (int e = 0; e < 3; e++) tok[e] = nt[e];
                            cnt[mc]++; mv = 1; ma = mc; fired = 1;
                        end
                    end
                    if (ms == 1) begin
                        if (mc == 2) begin
                            if (!mp && !fired) ms = 3;
                            mp = 0; mc = 0;
                        end else begin
                            mp = mp | fired; mc++;
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (ms == 1), "R3 busy", busy, ms == 1);
            check(fire_valid == mv, "R5 fire_valid", fire_valid, mv);
            if (mv) check(fire_actor == ma, "R5 fire_actor", fire_actor, ma);
            check(done == (ms == 2), "R6 done", done, ms == 2);
            check(tok_err == merr, "R6 tok_err", tok_err, merr);
            check(deadlock == (ms == 3), "R7 deadlock", deadlock, ms == 3);
            check(overflow == (ms == 4), "R8 overflow", overflow, ms == 4);
            if (fire_valid) seq.push_back(fire_actor);
        end
    end

    task automatic cfg_default();
        e_src  = {2'd1, 2'd0, 2'd0};
        e_dst  = {2'd2, 2'd2, 2'd1};
        e_prod = {4'd1, 4'd1, 4'd2};
        e_cons = {4'd1, 4'd2, 4'd4};
        e_init = '0;
        a_tgt  = {8'd1, 8'd1, 8'd2};
    endtask

    task automatic run(input int mid_start);
        seq.delete();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 200 && busy; i++) begin
            @(negedge clk);
            if (i == 1 && mid_start) start = 1;
            else start = 0;
        end
        start = 0;
    endtask

    task automatic check_seq(input string req, input int exp[$]);
        check(seq.size() == exp.size(), req, seq.size(), exp.size());
        if (seq.size() == exp.size())
            foreach (exp[i]) check(seq[i] == exp[i], req, seq[i], exp[i]);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 20000; wd++) @(posedge clk);
        check(0, "watchdog", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_default();
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, done, deadlock, overflow, tok_err, fire_valid} == 6'b0, "R1 reset", 1, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !fire_valid, "R1 idle", busy, 0);

        // R10, R4, R2: default graph, stray start mid-run
        run(1);
        check_seq("R10 order", '{0, 0, 1, 2});
        check(done && !tok_err, "R10 done clean", {done, tok_err}, 2);

        // R9 terminal hold
        repeat (4) @(negedge clk);
        check(done && !busy, "R9 hold", done, 1);

        // R7 reversed A-C edge, no tokens
        e_src = {2'd1, 2'd2, 2'd0};
        e_dst = {2'd2, 2'd0, 2'd1};
        run(0);
        check(deadlock && seq.size() == 0, "R7 deadlock no fire", seq.size(), 0);

        // R3, R4 start tokens change the order; restart from DEAD (R9)
        cfg_default();
        e_init = {8'd0, 8'd0, 8'd4};
        run(0);
        check_seq("R3 order with tokens", '{0, 1, 0, 2});
        check(done && !tok_err, "R4 marking restored", tok_err, 0);

        // R6 unbalanced targets leave a wrong marking
        cfg_default();
        a_tgt = {8'd0, 8'd0, 8'd1};
        run(0);
        check(done && tok_err, "R6 mismatch", tok_err, 1);

        // R8 overflow on first A
        cfg_default();
        e_init = {8'd0, 8'd0, 8'd254};
        run(0);
        check(overflow && seq.size() == 0, "R8 overflow stop", seq.size(), 0);
        repeat (3) @(negedge clk);
        check(overflow && !busy, "R9 ovf hold", overflow, 1);

        // R6 zero targets complete immediately
        cfg_default();
        a_tgt = '0;
        run(0);
        check(done && !tok_err && seq.size() == 0, "R6 zero targets", seq.size(), 0);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule